// File: doc/BRIEF.md
# ARINC 429 Receive Bit Validator

This block rebuilds serial ARINC 429 data from three digitised line-state indications (One, Zero, Null) that an external comparator front end supplies. It samples them from a 1 MHz reference clock, either on every clock (high-speed line) or on every eighth clock (low-speed line). Each state feeds a 10-sample history register. A data bit is recognised from run patterns in those histories, and the block enforces both the spacing between bits and the idle gap between words.

When 32 well-formed, correctly spaced bits have arrived, the block presents the assembled word and raises a one-clock end-of-sequence strobe. A reception that breaks the timing rules is dropped with a one-clock error pulse. The receiver then stays deaf until the line has shown a proper inter-word gap. Parity, label filtering and storage belong to downstream logic.

Top module: `arinc_rx_bitval`

## Requirements
- R1: While rst is high, rx_word is 0 and rx_eos and rx_err are 0. After reset the receiver waits for a word gap, so bits that arrive before the line has shown a full gap are ignored silently (no strobe and no error).
- R2: A sample on which more than one of lvl_one, lvl_zero and lvl_null is high counts as no state, so all three histories take a 0. A bit made only of such samples is not recognised.
- R3: A bit is recognised when the older half of the One or Zero history holds a run of at least 3 ones while the newer half of the Null history holds a run of at least 3 ones. A level pulse shorter than 3 samples is not a bit.
- R4: A recognised bit is accepted only if it comes 8 to 12 samples after the previous one. If 13 samples pass without an accepted bit during a reception, the word is aborted.
- R5: With hi_speed=1 the line is sampled on every clock. With hi_speed=0 it is sampled once every 8 clocks. All windows and timers are counted in samples.
- R6: After a completed or aborted word, a gap timer tests the Null history every 10 samples (80 clocks in low-speed mode). A new first bit is accepted only after 3 consecutive tests find a run of 3 in both halves of the Null history. A failed test restarts the count, and a word that starts during an incomplete gap is ignored silently.
- R7: The first bit received lands in rx_word[0] and the 32nd in rx_word[31], with a One level giving 1 and a Zero level giving 0. rx_word changes only in the clock where rx_eos is high, and rx_eos lasts one clock.
- R8: An aborted reception gives a one-clock rx_err pulse, never together with rx_eos, and no rx_eos for that word.
- R9: rx_eos is raised only once 32 bits have been accepted. A word that stops short, followed by an idle Null line, ends with rx_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz sampling reference |
| rst | input | 1 | Synchronous reset, active high |
| hi_speed | input | 1 | 1 selects high-speed sampling, 0 selects low-speed |
| lvl_one | input | 1 | Line is in the One band |
| lvl_zero | input | 1 | Line is in the Zero band |
| lvl_null | input | 1 | Line is in the Null band |
| rx_word | output | 32 | Last completed word, first bit in bit 0 |
| rx_eos | output | 1 | One-clock strobe for a completed word |
| rx_err | output | 1 | One-clock strobe for an aborted reception |

## Verification
Random words are sent at random bit spacings drawn from 8 to 12 samples, in both speed modes. These show that data, bit order and the sampling rate are right across the whole accepted window. Directed words then stretch one bit to 13 samples, shrink one pulse to 2 samples, drive two levels at once on one bit, or stop after 31 bits. Each of these separates a correct abort from a silent drop or a false accept. A word sent straight after reset, and a word that follows a too-short gap, must both vanish without an error pulse, while the next properly gapped word is still received.

// File: rtl/arinc_rx_pkg.sv
package arinc_rx_pkg;

   // line-state index inside the sampler bank
   localparam int LV_ONE  = 0;
   localparam int LV_ZERO = 1;
   localparam int LV_NULL = 2;
   localparam int LV_NUM  = 3;

   typedef enum logic [1:0] {
      ST_GAP   = 2'd0,   // waiting for an inter-word gap
      ST_READY = 2'd1,   // gap seen, waiting for a first bit
      ST_RECV  = 2'd2    // collecting bits
   } rx_state_e;

endpackage

// File: rtl/arinc_rx_tick.sv
module arinc_rx_tick #(
   parameter int LS_DIV = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic hi_speed,
   output logic samp_en
);
   localparam int DIV_W = (LS_DIV > 2) ? $clog2(LS_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(LS_DIV - 1);

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (rst)                  div_q <= '0;
      else if (div_q == DIV_LAST) div_q <= '0;
      else                      div_q <= div_q + DIV_W'(1);
   end

   assign samp_en = hi_speed | (div_q == '0);
endmodule

// File: rtl/arinc_rx_samplers.sv
module arinc_rx_samplers
   import arinc_rx_pkg::*;
#(
   parameter int SR_LEN = 10
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           samp_en,
   input  logic [LV_NUM-1:0]              lvl,
   output logic [LV_NUM-1:0][SR_LEN-1:0]  sr_o,
   output logic                           strobe_o
);
   // a sample is only meaningful when exactly one band is reported
   logic excl;
   assign excl = $onehot(lvl);

   for (genvar g = 0; g < LV_NUM; g++) begin : g_hist
      logic [SR_LEN-1:0] hist_q;
      always_ff @(posedge clk) begin
         if (rst)          hist_q <= '0;
         else if (samp_en) hist_q <= {hist_q[SR_LEN-2:0], lvl[g] & excl};
      end
      assign sr_o[g] = hist_q;
   end

   // marks the clock in which freshly shifted histories are visible
   always_ff @(posedge clk) begin
      if (rst) strobe_o <= 1'b0;
      else     strobe_o <= samp_en;
   end
endmodule

// File: rtl/arinc_rx_detect.sv
module arinc_rx_detect
   import arinc_rx_pkg::*;
#(
   parameter int SR_LEN = 10,
   parameter int RUN    = 3
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           strobe,
   input  logic [LV_NUM-1:0][SR_LEN-1:0]  sr_i,
   output logic                           bit_evt,
   output logic                           bit_val,
   output logic                           gap_null
);
   localparam int HALF = SR_LEN / 2;

   // true when v[base +: HALF] holds RUN consecutive ones
   function automatic logic run_at(input logic [SR_LEN-1:0] v, input int base);
      logic hit;
      logic all1;
      hit = 1'b0;
      for (int i = 0; i <= HALF - RUN; i++) begin
         all1 = 1'b1;
         for (int j = 0; j < RUN; j++) all1 = all1 & v[base + i + j];
         hit = hit | all1;
      end
      return hit;
   endfunction

   logic one_old, zero_old, null_new, null_old, cond, cond_q;

   // older samples sit in the upper half, newest in bit 0
   assign one_old  = run_at(sr_i[LV_ONE],  HALF);
   assign zero_old = run_at(sr_i[LV_ZERO], HALF);
   assign null_new = run_at(sr_i[LV_NULL], 0);
   assign null_old = run_at(sr_i[LV_NULL], HALF);

   assign cond = (one_old | zero_old) & null_new;

   always_ff @(posedge clk) begin
      if (rst)         cond_q <= 1'b0;
      else if (strobe) cond_q <= cond;
   end

   assign bit_evt  = strobe & cond & ~cond_q;
   assign bit_val  = one_old;
   assign gap_null = null_new & null_old;
endmodule

// File: rtl/arinc_rx_framer.sv
module arinc_rx_framer
   import arinc_rx_pkg::*;
#(
   parameter int WORD_BITS  = 32,
   parameter int MIN_SPC    = 8,
   parameter int MAX_SPC    = 12,
   parameter int GAP_PERIOD = 10,
   parameter int GAP_CHECKS = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 strobe,
   input  logic                 bit_evt,
   input  logic                 bit_val,
   input  logic                 gap_null,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 eos_o,
   output logic                 err_o
);
   localparam int SPC_W = $clog2(MAX_SPC + 2);
   localparam int NB_W  = $clog2(WORD_BITS + 1);
   localparam int GT_W  = $clog2(GAP_PERIOD);
   localparam int GC_W  = $clog2(GAP_CHECKS + 1);

   localparam logic [SPC_W-1:0] MIN_L   = SPC_W'(MIN_SPC);
   localparam logic [SPC_W-1:0] MAX_L   = SPC_W'(MAX_SPC);
   localparam logic [NB_W-1:0]  NB_LAST = NB_W'(WORD_BITS - 1);
   localparam logic [GT_W-1:0]  GT_LAST = GT_W'(GAP_PERIOD - 1);
   localparam logic [GC_W-1:0]  GC_LAST = GC_W'(GAP_CHECKS - 1);

   rx_state_e            state_q;
   logic [SPC_W-1:0]     spc_q;
   logic [NB_W-1:0]      nbits_q;
   logic [WORD_BITS-1:0] asm_q;
   logic [GT_W-1:0]      gtim_q;
   logic [GC_W-1:0]      gcnt_q;

   logic [SPC_W-1:0]     elapsed;
   logic [WORD_BITS-1:0] asm_nx;
   logic                 spc_ok;

   always_comb begin
      elapsed = spc_q + SPC_W'(1);
      asm_nx  = {bit_val, asm_q[WORD_BITS-1:1]};
      spc_ok  = (elapsed >= MIN_L) && (elapsed <= MAX_L);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_GAP;
         spc_q   <= '0;
         nbits_q <= '0;
         asm_q   <= '0;
         gtim_q  <= '0;
         gcnt_q  <= '0;
         word_o  <= '0;
         eos_o   <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         eos_o <= 1'b0;
         err_o <= 1'b0;
         if (strobe) begin
            case (state_q)
               ST_GAP: begin
                  if (gtim_q == GT_LAST) begin
                     gtim_q <= '0;
                     if (!gap_null)              gcnt_q <= '0;
                     else if (gcnt_q == GC_LAST) begin
                        gcnt_q  <= '0;
                        state_q <= ST_READY;
                     end else                    gcnt_q <= gcnt_q + GC_W'(1);
                  end else begin
                     gtim_q <= gtim_q + GT_W'(1);
                  end
               end
               ST_READY: begin
                  if (bit_evt) begin
                     asm_q   <= asm_nx;
                     nbits_q <= NB_W'(1);
                     spc_q   <= '0;
                     state_q <= ST_RECV;
                  end
               end
               ST_RECV: begin
                  if ((bit_evt && !spc_ok) || (!bit_evt && elapsed > MAX_L)) begin
                     err_o   <= 1'b1;
                     state_q <= ST_GAP;
                     gtim_q  <= '0;
                     gcnt_q  <= '0;
                  end else if (bit_evt) begin
                     asm_q   <= asm_nx;
                     spc_q   <= '0;
                     nbits_q <= nbits_q + NB_W'(1);
                     if (nbits_q == NB_LAST) begin
                        word_o  <= asm_nx;
                        eos_o   <= 1'b1;
                        state_q <= ST_GAP;
                        gtim_q  <= '0;
                        gcnt_q  <= '0;
                     end
                  end else begin
                     spc_q <= elapsed;
                  end
               end
               default: state_q <= ST_GAP;
            endcase
         end
      end
   end
endmodule

// File: rtl/arinc_rx_bitval.sv
module arinc_rx_bitval
   import arinc_rx_pkg::*;
#(
   parameter int WORD_BITS  = 32,
   parameter int SR_LEN     = 10,
   parameter int RUN        = 3,
   parameter int MIN_SPC    = 8,
   parameter int MAX_SPC    = 12,
   parameter int GAP_PERIOD = 10,
   parameter int GAP_CHECKS = 3,
   parameter int LS_DIV     = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 hi_speed,
   input  logic                 lvl_one,
   input  logic                 lvl_zero,
   input  logic                 lvl_null,
   output logic [WORD_BITS-1:0] rx_word,
   output logic                 rx_eos,
   output logic                 rx_err
);
   // elaboration-time parameter checks
   if (SR_LEN % 2 != 0 || RUN < 1 || RUN > SR_LEN / 2) begin : g_bad_hist
      $error("history length must be even and hold a run in each half");
   end
   if (MIN_SPC < 1 || MIN_SPC > MAX_SPC) begin : g_bad_spc
      $error("bit spacing window is empty");
   end
   if (WORD_BITS < 2 || LS_DIV < 2 || GAP_PERIOD < 2 || GAP_CHECKS < 1) begin : g_bad_misc
      $error("word, divider or gap parameters out of range");
   end

   logic                          samp_en;
   logic                          strobe;
   logic [LV_NUM-1:0][SR_LEN-1:0] sr;
   logic [LV_NUM-1:0]             lvl;
   logic [LV_NUM-1:0]             newest;
   logic                          bit_evt, bit_val, gap_null;

   always_comb begin
      lvl          = '0;
      lvl[LV_ONE]  = lvl_one;
      lvl[LV_ZERO] = lvl_zero;
      lvl[LV_NULL] = lvl_null;
      for (int i = 0; i < LV_NUM; i++) newest[i] = sr[i][0];
   end

   arinc_rx_tick #(.LS_DIV(LS_DIV)) u_tick (
      .clk(clk), .rst(rst), .hi_speed(hi_speed), .samp_en(samp_en)
   );

   arinc_rx_samplers #(.SR_LEN(SR_LEN)) u_samp (
      .clk(clk), .rst(rst), .samp_en(samp_en), .lvl(lvl),
      .sr_o(sr), .strobe_o(strobe)
   );

   arinc_rx_detect #(.SR_LEN(SR_LEN), .RUN(RUN)) u_det (
      .clk(clk), .rst(rst), .strobe(strobe), .sr_i(sr),
      .bit_evt(bit_evt), .bit_val(bit_val), .gap_null(gap_null)
   );

   arinc_rx_framer #(
      .WORD_BITS(WORD_BITS), .MIN_SPC(MIN_SPC), .MAX_SPC(MAX_SPC),
      .GAP_PERIOD(GAP_PERIOD), .GAP_CHECKS(GAP_CHECKS)
   ) u_frm (
      .clk(clk), .rst(rst), .strobe(strobe), .bit_evt(bit_evt),
      .bit_val(bit_val), .gap_null(gap_null),
      .word_o(rx_word), .eos_o(rx_eos), .err_o(rx_err)
   );
endmodule

// File: rtl/arinc_rx_bitval_chk.sv
module arinc_rx_bitval_chk #(
   parameter int WORD_BITS = 32
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 hi_speed,
   input logic                 samp_en,
   input logic [2:0]           newest,
   input logic [WORD_BITS-1:0] rx_word,
   input logic                 rx_eos,
   input logic                 rx_err
);
   // R2: at most one history takes a 1 per sample
   a_r2_newest_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(newest));

   // R5: in low-speed mode samples are never on adjacent clocks
   a_r5_low_speed_rate: assert property (@(posedge clk) disable iff (rst)
      (!hi_speed && $past(!hi_speed) && $past(samp_en)) |-> !samp_en);

   // R7: end-of-sequence lasts one clock
   a_r7_eos_single: assert property (@(posedge clk) disable iff (rst)
      rx_eos |=> !rx_eos);

   // R7: output word only moves with the strobe
   a_r7_word_on_eos: assert property (@(posedge clk) disable iff (rst)
      !$stable(rx_word) |-> rx_eos);

   // R8: error lasts one clock
   a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
      rx_err |=> !rx_err);

   // R8: error and completion never coincide
   a_r8_err_not_eos: assert property (@(posedge clk) disable iff (rst)
      !(rx_err && rx_eos));
endmodule

bind arinc_rx_bitval arinc_rx_bitval_chk #(.WORD_BITS(WORD_BITS)) u_chk (
   .clk(clk), .rst(rst), .hi_speed(hi_speed), .samp_en(samp_en),
   .newest(newest), .rx_word(rx_word), .rx_eos(rx_eos), .rx_err(rx_err)
);

// File: tb/arinc_rx_bitval_tb.sv
`timescale 1ns/1ps
module arinc_rx_bitval_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hi_speed = 1'b1;
   logic        lvl_one = 1'b0, lvl_zero = 1'b0, lvl_null = 1'b0;
   logic [31:0] rx_word;
   logic        rx_eos, rx_err;

   int n_checks = 0, n_fail = 0;
   int n_eos = 0, n_err = 0;
   logic [31:0] got_word = '0;
   int sp[32];
   int bad_bit = -1, bad_kind = 0;
   bit done = 0;

   always #5 clk = ~clk;

   arinc_rx_bitval u_dut (
      .clk(clk), .rst(rst), .hi_speed(hi_speed), .lvl_one(lvl_one),
      .lvl_zero(lvl_zero), .lvl_null(lvl_null),
      .rx_word(rx_word), .rx_eos(rx_eos), .rx_err(rx_err)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (rx_eos) begin n_eos++; got_word = rx_word; end
         if (rx_err) n_err++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_word(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // hold a line state for n samples; v = {null, zero, one}
   task automatic put(input logic [2:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         {lvl_null, lvl_zero, lvl_one} = v;
         repeat (hi_speed ? 1 : 8) @(negedge clk);
      end
   endtask

   task automatic send_word(input logic [31:0] w, input int nb);
      for (int k = 0; k < nb; k++) begin
         int hw = 5;
         logic dbl = 1'b0;
         if (k == bad_bit && bad_kind == 1) hw = 2;
         if (k == bad_bit && bad_kind == 2) dbl = 1'b1;
         put({dbl, ~w[k], w[k]}, hw);
         put(3'b100, sp[k] - hw);
      end
   endtask

   // expected outcome from the spacing and shape rules
   function automatic bit predict(input int nb);
      if (nb != 32 || bad_bit >= 0) return 1'b0;
      for (int k = 0; k < 31; k++)
         if (sp[k] < 8 || sp[k] > 12) return 1'b0;
      return 1'b1;
   endfunction

   task automatic fill_sp();
      for (int k = 0; k < 32; k++) sp[k] = 8 + int'($urandom % 5);
   endtask

   task automatic run_case(input string req, input logic [31:0] w, input int nb);
      int e0 = n_eos, r0 = n_err;
      bit acc;
      send_word(w, nb);
      put(3'b100, 45);
      repeat (4) @(negedge clk);
      acc = predict(nb);
      chk({req, " eos"}, n_eos - e0, int'(acc));
      chk({req, " err"}, n_err - r0, int'(!acc));
      if (acc) chk_word({req, " word"}, got_word, w);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      int e0, r0;
      void'($urandom(32'd4291));
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 reset eos", int'(rx_eos), 0);
      chk("R1 reset err", int'(rx_err), 0);
      chk_word("R1 reset word", rx_word, 32'h0);
      rst = 1'b0;

      // R1 a word before any gap is dropped silently
      fill_sp();
      e0 = n_eos; r0 = n_err;
      send_word(32'hA5A5_0F0F, 32);
      put(3'b100, 45);
      repeat (4) @(negedge clk);
      chk("R1 no-gap eos", n_eos - e0, 0);
      chk("R1 no-gap err", n_err - r0, 0);

      // R7 R3 directed patterns with random spacing
      fill_sp(); run_case("R7 ones", 32'hFFFF_FFFF, 32);
      fill_sp(); run_case("R7 zeros", 32'h0000_0000, 32);
      fill_sp(); run_case("R7 order", 32'h0000_0001, 32);

      // R4 window edges
      for (int k = 0; k < 32; k++) sp[k] = 8;
      run_case("R4 min spacing", 32'h1234_5678, 32);
      for (int k = 0; k < 32; k++) sp[k] = 12;
      run_case("R4 max spacing", 32'h8765_4321, 32);

      // random words, some with a stretched bit
      for (int n = 0; n < 12; n++) begin
         fill_sp();
         if ($urandom % 4 == 0) sp[1 + int'($urandom % 29)] = 13;
         w = $urandom;
         run_case("R4 random", w, 32);
      end

      // R4 R8 one late bit
      fill_sp(); sp[10] = 13;
      run_case("R8 late bit", 32'hCAFE_F00D, 32);

      // R3 short pulse
      fill_sp(); bad_bit = 7; bad_kind = 1;
      run_case("R3 short pulse", 32'hFFFF_0000, 32);
      // R2 two levels at once
      fill_sp(); bad_bit = 20; bad_kind = 2;
      run_case("R2 double level", 32'h5555_AAAA, 32);
      bad_bit = -1; bad_kind = 0;

      // R9 word cut short
      fill_sp();
      run_case("R9 31 bits", 32'h7FFF_FFFF, 31);

      // R6 short gap hides the following word
      fill_sp();
      e0 = n_eos; r0 = n_err;
      send_word(32'h1111_2222, 32);
      put(3'b100, 5);
      fill_sp();
      send_word(32'h3333_4444, 32);
      put(3'b100, 45);
      repeat (4) @(negedge clk);
      chk("R6 short gap eos", n_eos - e0, 1);
      chk_word("R6 short gap word", got_word, 32'h1111_2222);
      fill_sp(); run_case("R6 after gap", 32'h5555_6666, 32);
      chk("R6 short gap err", n_err - r0, 0);

      // R5 low-speed sampling
      hi_speed = 1'b0;
      put(3'b100, 40);
      for (int n = 0; n < 2; n++) begin
         fill_sp();
         w = $urandom;
         run_case("R5 low speed", w, 32);
      end
      fill_sp(); sp[4] = 13;
      run_case("R5 low speed late", 32'h0F0F_F0F0, 32);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_fail);
      $finish;
   end
endmodule